// File: doc/BRIEF.md
# I/Q Serial Output Framer

This block takes complex sample pairs, a 16-bit in-phase word and a 16-bit quadrature word, from a one-entry output buffer and sends them out bit-serially on three lines: a serial clock, a frame sync and a data line. The producer writes a pair through a valid/ready port. Once the buffer holds a pair the ready line drops, and the producer stays stalled until a start pulse drains the buffer into the shift register.

A start pulse one system clock wide begins a frame. The serial clock runs at half the system clock rate. It is made from a clock enable, so the whole block stays in one clock domain. Its first rising edge comes two system clocks after the edge that samples the start pulse. Frame sync and data change on the rising edges of the serial clock. A configuration input inverts the serial clock pin, so the output can feed a serial input that samples on the other edge. Between frames the data line rests at 0 and the serial clock stays at its idle level.

Top module: `iqSerFramer`

## Requirements
- R1: After reset, inReady is 1, serData is 0, serFs is 0 and the uninverted serial clock is 0.
- R2: The buffer holds one pair. A pair is written when inValid and inReady are both 1. inReady stays 0 while the buffer is full and no start is draining it.
- R3: A start pulse while the buffer is full and no frame is running moves the pair into the shift register and empties the buffer. inReady is 1 in that same cycle, so a pair offered then is stored as the next entry.
- R4: The first rising edge of the uninverted serial clock falls on the second system clock edge after the edge that samples the start pulse. After that the rising edges come every 2 system clocks, 32 per frame.
- R5: On successive rising edges the data line carries I bit 15 down to I bit 0, then Q bit 15 down to Q bit 0.
- R6: serFs is 1 for the serial clock period that carries I bit 15, and 0 for the other 31 bit periods.
- R7: A start pulse while the buffer is empty starts no frame. The serial clock makes no rising edge and serData stays 0.
- R8: A start pulse while a frame is running is ignored. The current frame goes on unchanged and the buffered pair is kept for a later start.
- R9: With cfgInvClk at 1 the serClk pin carries the inverse of the serial clock, so it idles at 1. Data and sync timing do not change.
- R10: Outside a frame, serData is 0 and the uninverted serial clock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Producer offers a pair |
| inI | input | 16 | In-phase sample |
| inQ | input | 16 | Quadrature sample |
| inReady | output | 1 | Buffer can take a pair this cycle |
| startIn | input | 1 | One-cycle frame start pulse |
| cfgInvClk | input | 1 | Invert the serial clock pin |
| serClk | output | 1 | Serial clock, system clock divided by 2 |
| serFs | output | 1 | Frame sync, high during I bit 15 |
| serData | output | 1 | Serial data, MSB first |

## Verification
A producer write and a buffer drain can happen in the same cycle. When a start pulse empties a full buffer, inReady rises in that cycle, and the bench offers a fresh pair in that cycle. It checks that inReady is 1 while the start is applied, that the old pair goes out as the current frame, and that the fresh pair, not a lost or doubled one, forms the next frame. A start pulse is also issued in the middle of a frame while the buffer is full. The bench then confirms that the frame count does not move and that the buffer still stalls the producer.

// File: rtl/iqSerFramerPkg.sv
package iqSerFramerPkg;
  typedef struct packed {
    logic load;   // copy buffer into shift register, empty buffer
    logic shift;  // serial clock rising edge: present next bit
    logic first;  // this shift carries the first bit of the frame
    logic done;   // frame finished: return line to rest
  } ctlStrobes_t;
endpackage

// File: rtl/iqSerFramerCtrl.sv
module iqSerFramerCtrl
  import iqSerFramerPkg::*;
#(
  parameter int FRAME_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        bufFull,
  output logic        busy,
  output ctlStrobes_t ctl
);
  localparam int LAST_PH = 2 * FRAME_W + 1;
  localparam int PH_W    = $clog2(LAST_PH + 1);
  localparam logic [PH_W-1:0] LAST_SHIFT = PH_W'(2 * FRAME_W - 1);
  localparam logic [PH_W-1:0] DONE_PH    = PH_W'(LAST_PH);

  logic [PH_W-1:0] phase;

  always_comb begin
    ctl.load  = startIn && bufFull && !busy;
    ctl.shift = busy && phase[0] && (phase <= LAST_SHIFT);
    ctl.first = ctl.shift && (phase == PH_W'(1));
    ctl.done  = busy && (phase == DONE_PH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (ctl.load) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (ctl.done) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (busy) begin
      phase <= phase + 1'b1;
    end
  end

  // R7
  empty_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !bufFull && !busy) |=> !busy);
  // R8
  busy_start_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startIn && bufFull) |=> bufFull);
endmodule

// File: rtl/iqSerFramerData.sv
module iqSerFramerData
  import iqSerFramerPkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  output logic                inReady,
  output logic                bufFull,
  output logic                sclkRaw,
  output logic                serFs,
  output logic                serData
);
  localparam int FRAME_W = 2 * SAMPLE_W;

  logic [SAMPLE_W-1:0] bufI, bufQ;
  logic [FRAME_W-1:0]  shReg;
  logic                writeFire;

  assign inReady   = !bufFull || ctl.load;
  assign writeFire = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      bufI    <= '0;
      bufQ    <= '0;
    end else if (writeFire) begin
      bufFull <= 1'b1;
      bufI    <= inI;
      bufQ    <= inQ;
    end else if (ctl.load) begin
      bufFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      sclkRaw <= 1'b0;
      serFs   <= 1'b0;
      serData <= 1'b0;
    end else begin
      sclkRaw <= ctl.shift;
      if (ctl.load) begin
        shReg <= {bufI, bufQ};
      end else if (ctl.shift) begin
        shReg   <= {shReg[FRAME_W-2:0], 1'b0};
        serData <= shReg[FRAME_W-1];
        serFs   <= ctl.first;
      end else if (ctl.done) begin
        serData <= 1'b0;
        serFs   <= 1'b0;
      end
    end
  end

  // R2
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !ctl.load) |=> bufFull);
  // R6
  fs_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serFs) |-> $rose(sclkRaw));
endmodule

// File: rtl/iqSerFramer.sv
module iqSerFramer
  import iqSerFramerPkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  output logic                inReady,
  input  logic                startIn,
  input  logic                cfgInvClk,
  output logic                serClk,
  output logic                serFs,
  output logic                serData
);
  localparam int FRAME_W = 2 * SAMPLE_W;

  ctlStrobes_t ctl;
  logic busy, bufFull, sclkRaw;

  iqSerFramerCtrl #(.FRAME_W(FRAME_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .bufFull(bufFull),
    .busy(busy), .ctl(ctl)
  );

  iqSerFramerData #(.SAMPLE_W(SAMPLE_W)) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inValid(inValid), .inI(inI),
    .inQ(inQ), .inReady(inReady), .bufFull(bufFull), .sclkRaw(sclkRaw),
    .serFs(serFs), .serData(serData)
  );

  assign serClk = sclkRaw ^ cfgInvClk;

  // R10
  idle_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serData && !sclkRaw && !serFs));
  // R4
  no_edge_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !sclkRaw);
endmodule

// File: tb/iqSerFramer_tb_top.sv
module iqSerFramer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inI = '0, inQ = '0;
  logic inReady;
  logic startIn = 1'b0;
  logic cfgInvClk = 1'b0;
  logic serClk, serFs, serData;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int frames = 0;
  int startCyc = 0;
  int bitIdx = 0;
  int lastRiseCyc = 0;
  int rises = 0;
  bit prevRaw = 1'b0;
  bit fsOk, perOk;
  bit finished = 1'b0;
  logic [31:0] shw;
  logic [31:0] expQ[$];

  iqSerFramer dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .inReady(inReady), .startIn(startIn), .cfgInvClk(cfgInvClk),
    .serClk(serClk), .serFs(serFs), .serData(serData)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: collect bits on serial clock rising edges, compare with scoreboard
  always @(negedge clk) begin
    bit raw;
    if (rstN) begin
      raw = serClk ^ cfgInvClk;
      if (raw && !prevRaw) begin
        rises++;
        if (bitIdx == 0) begin
          // R4 first edge two clocks after the sampling edge of start
          check(cyc == startCyc + 3, "R4 latency", cyc - startCyc, 3);
          fsOk = serFs;
          perOk = 1'b1;
        end else begin
          if (serFs) fsOk = 1'b0;
          if (cyc - lastRiseCyc != 2) perOk = 1'b0;
        end
        shw = {shw[30:0], serData};
        lastRiseCyc = cyc;
        bitIdx++;
        if (bitIdx == 32) begin
          logic [31:0] e;
          bitIdx = 0;
          frames++;
          e = (expQ.size() > 0) ? expQ.pop_front() : 32'hxxxxxxxx;
          check(shw === e, "R5 frame payload", shw, e);
          check(fsOk, "R6 sync pattern", fsOk, 1);
          check(perOk, "R4 edge spacing", perOk, 1);
        end
      end
      prevRaw = raw;
    end
  end

  task automatic writePair(input logic [15:0] i, input logic [15:0] q);
    @(negedge clk);
    inValid = 1'b1; inI = i; inQ = q;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    expQ.push_back({i, q});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startIn = 1'b1;
    startCyc = cyc;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    int f0, r0;
    waitCycles(4);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    check(inReady == 1'b1, "R1 inReady", inReady, 1);
    check(serData == 1'b0 && serFs == 1'b0, "R1 data/sync", {serData, serFs}, 0);
    check(serClk == 1'b0, "R1 clock", serClk, 0);

    // R7 start with empty buffer
    r0 = rises;
    pulseStart();
    waitCycles(80);
    check(rises == r0, "R7 no edges", rises - r0, 0);
    check(serData == 1'b0, "R7 data rest", serData, 0);

    // R2 stall while full
    writePair(16'hA5C3, 16'h0F1E);
    #1;
    check(inReady == 1'b0, "R2 ready low when full", inReady, 0);
    inValid = 1'b1; inI = 16'h1111; inQ = 16'h2222;
    waitCycles(3);
    #1;
    check(inReady == 1'b0, "R2 ready held low", inReady, 0);
    inValid = 1'b0;

    pulseStart();
    waitCycles(72);
    check(frames == 1, "R5 first frame", frames, 1);
    // R10 rest between frames
    check(serData == 1'b0 && serClk == 1'b0, "R10 rest", {serData, serClk}, 0);

    // R3 same-cycle drain and write
    writePair(16'h1234, 16'hFEDC);
    @(negedge clk);
    startIn = 1'b1; startCyc = cyc;
    inValid = 1'b1; inI = 16'h6B2D; inQ = 16'h90F7;
    #1;
    check(inReady == 1'b1, "R3 ready during drain", inReady, 1);
    expQ.push_back({16'h6B2D, 16'h90F7});
    @(negedge clk);
    startIn = 1'b0; inValid = 1'b0;
    #1;
    check(inReady == 1'b0, "R3 refilled buffer", inReady, 0);

    // R8 start during a frame is ignored
    waitCycles(20);
    f0 = frames;
    @(negedge clk) startIn = 1'b1;
    @(negedge clk) startIn = 1'b0;
    waitCycles(130);
    check(frames == f0 + 1, "R8 no extra frame", frames - f0, 1);
    #1;
    check(inReady == 1'b0, "R8 buffer kept", inReady, 0);
    pulseStart();
    waitCycles(72);
    check(frames == 3, "R3 refill sent", frames, 3);

    // R9 inverted clock
    cfgInvClk = 1'b1;
    #1;
    check(serClk == 1'b1, "R9 idle inverted", serClk, 1);
    writePair(16'h8000, 16'h0001);
    pulseStart();
    waitCycles(72);
    check(frames == 4, "R9 frame count", frames, 4);
    cfgInvClk = 1'b0;

    writePair(16'hFFFF, 16'h0000);
    pulseStart();
    waitCycles(72);
    check(frames == 5, "R5 frame count", frames, 5);
    check(serData == 1'b0 && serClk == 1'b0 && serFs == 1'b0, "R10 final rest",
          {serData, serClk, serFs}, 0);
    check(expQ.size() == 0, "R5 scoreboard empty", expQ.size(), 0);
    finished = 1'b1;
    finishRun();
  end
endmodule